// File: doc/BRIEF.md
# Data-Ready Triggered ADC Read Sequencer

This block is the master side of a link to a delta-sigma converter that flags each fresh result by pulling an active-low ready line. When that line falls, the sequencer lowers chip select, shifts a one-byte read command out on MOSI, pauses for the converter to prepare its answer, and then clocks the result in from MISO. Data changes on the rising SCLK edge and is sampled on the falling edge. SCLK idles low. The SCLK half-period, the chip-select setup time and the command-to-response pause are all set in system clock cycles.

A finished read is reported as a 24-bit two's-complement value with a one-cycle valid strobe. A read may be cut short after 16 bits, which are then sign-extended. This is allowed only while the sequencer drives chip select itself. When chip select is tied low permanently, every read runs the full 24 bits. If the converter signals a new result before the current read has finished, the block raises an overrun pulse. The read in progress still completes.

Top module: `adc_rdy_reader`

## Requirements
- R1: While reset is asserted, cs_n is 1, and sclk, mosi, sample_valid, overrun and sample are all 0.
- R2: A read starts only on a high-to-low transition of drdy_n. drdy_n passes through a two-flop synchronizer, so the sequencer acts on the third rising clock edge at which it samples drdy_n low after a high sample. Steady levels and rising transitions start nothing.
- R3: Every read first sends the command byte 0x01 on mosi, MSB first. A new bit appears at each rising SCLK edge and holds through the falling edge. mosi is 0 outside the command.
- R4: SCLK idles low. Each SCLK high phase and each low phase within a byte lasts D system cycles, where D is half_div and a value of 0 counts as 1.
- R5: With cs_hold = 0, the first rising SCLK edge comes exactly max(cs_setup,1) cycles after cs_n falls.
- R6: The time from the last command falling SCLK edge to the first data rising SCLK edge is D + max(cmd_gap,1) cycles.
- R7: Result bits are captured from miso on falling SCLK edges, MSB first. A 24-bit read appears unchanged on sample.
- R8: With cs_hold = 0 and bits16 = 1 at the start of the read, exactly 16 data bits are clocked. sample then carries those bits in [15:0], and bit 15 is copied into [23:16].
- R9: With cs_hold = 1, cs_n stays 0 at all times. The first rising SCLK edge comes at the edge that acts on the drdy_n event. bits16 is ignored and 24 bits are always read.
- R10: sample_valid is high for exactly one cycle, one cycle after the last data bit is captured. With cs_hold = 0, cs_n returns high in that same cycle. sample holds its value until the next read completes.
- R11: A drdy_n fall that arrives while a read is in progress gives a one-cycle overrun pulse. The current read finishes unchanged, and that event does not start another read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_n | input | 1 | Active-low result-ready line from the converter |
| miso | input | 1 | Serial data from the converter |
| cs_hold | input | 1 | 1: chip select is kept low permanently |
| bits16 | input | 1 | 1: request a 16-bit read for the next transaction |
| half_div | input | 16 | SCLK half-period in system cycles (0 means 1) |
| cs_setup | input | 16 | Cycles from chip select low to the first SCLK rise (0 means 1) |
| cmd_gap | input | 16 | Extra cycles between the command and the data (0 means 1) |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command data |
| sample | output | 24 | Last result, two's complement, sign-extended for 16-bit reads |
| sample_valid | output | 1 | One-cycle strobe when sample updates |
| overrun | output | 1 | One-cycle pulse when a new ready edge hits a busy read |

## Verification
Two events can land in the same cycle: a new ready event and the final cycles of a read. When that happens, the overrun report and the completion strobe must coexist without the read being dropped or restarted. The bench lowers drdy_n a second time while the data bits are still being clocked. A reference model tracks the expected cs_n, SCLK, MOSI, strobe and overrun waveforms one clock at a time. The bench checks that exactly one overrun pulse appears, that the original word is still delivered, and that no second read follows.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_GAP,
    ST_DATA,
    ST_DONE
  } rd_state_t;

endpackage

// File: rtl/adc_rd_edge.sv
module adc_rd_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n,
  output logic fall_evt
);

  // chain[0] is the first synchronizer stage; chain[SYNC] is the history bit
  logic [SYNC:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[SYNC-1:0], drdy_n};
  end

  assign fall_evt = chain[SYNC] & ~chain[SYNC-1];

  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  function automatic logic [DIV_W-1:0] at_least_one(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  assign lim  = at_least_one(half_div) - DIV_W'(1);
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0 && $stable(half_div)) |=> !tick);

endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
  import adc_rd_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int RES_W   = 24,
  parameter int SHORT_W = 16,
  parameter int CMD_W   = 8,
  parameter logic [CMD_W-1:0] CMD_BYTE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_evt,
  input  logic             tick,
  input  logic             miso,
  input  logic             cs_hold,
  input  logic             bits16,
  input  logic [DIV_W-1:0] cs_setup,
  input  logic [DIV_W-1:0] cmd_gap,
  output logic             div_en,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic [RES_W-1:0] sample,
  output logic             sample_valid,
  output logic             overrun
);

  localparam int BIT_W = $clog2(RES_W + 1);

  rd_state_t        state;
  logic [DIV_W-1:0] wcnt;
  logic [BIT_W-1:0] bitcnt;
  logic [CMD_W-1:0] cmd_sr;
  logic [RES_W-1:0] shreg;
  logic             hold_q;
  logic             short_q;

  logic             busy;
  logic [DIV_W-1:0] setup_last;
  logic [DIV_W-1:0] gap_last;
  logic             last_bit;

  function automatic logic [DIV_W-1:0] at_least_one(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  function automatic logic [RES_W-1:0] widen(input logic [RES_W-1:0] raw,
                                             input logic             short_rd);
    logic [RES_W-1:0] r;
    if (short_rd) r = {{(RES_W-SHORT_W){raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
    else          r = raw;
    return r;
  endfunction

  function automatic logic [BIT_W-1:0] data_top(input logic short_rd);
    return short_rd ? BIT_W'(SHORT_W - 1) : BIT_W'(RES_W - 1);
  endfunction

  assign busy       = (state != ST_IDLE);
  assign setup_last = at_least_one(cs_setup) - DIV_W'(1);
  assign gap_last   = at_least_one(cmd_gap) - DIV_W'(1);
  assign last_bit   = (bitcnt == '0);
  assign div_en     = (state == ST_CMD) || (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      wcnt         <= '0;
      bitcnt       <= '0;
      cmd_sr       <= '0;
      shreg        <= '0;
      hold_q       <= 1'b0;
      short_q      <= 1'b0;
      sclk         <= 1'b0;
      cs_n         <= 1'b1;
      mosi         <= 1'b0;
      sample       <= '0;
      sample_valid <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      overrun      <= fall_evt && busy;
      unique case (state)
        ST_IDLE: begin
          cs_n <= !cs_hold;
          sclk <= 1'b0;
          mosi <= 1'b0;
          if (fall_evt) begin
            hold_q  <= cs_hold;
            short_q <= bits16 && !cs_hold;
            shreg   <= '0;
            cs_n    <= 1'b0;
            if (cs_hold) begin
              state  <= ST_CMD;
              sclk   <= 1'b1;
              mosi   <= CMD_BYTE[CMD_W-1];
              cmd_sr <= CMD_BYTE << 1;
              bitcnt <= BIT_W'(CMD_W - 1);
            end else begin
              state <= ST_SETUP;
              wcnt  <= '0;
            end
          end
        end
        ST_SETUP: begin
          if (wcnt == setup_last) begin
            state  <= ST_CMD;
            sclk   <= 1'b1;
            mosi   <= CMD_BYTE[CMD_W-1];
            cmd_sr <= CMD_BYTE << 1;
            bitcnt <= BIT_W'(CMD_W - 1);
          end else begin
            wcnt <= wcnt + DIV_W'(1);
          end
        end
        ST_CMD: begin
          if (tick) begin
            if (sclk) begin
              sclk <= 1'b0;
            end else if (last_bit) begin
              state <= ST_GAP;
              wcnt  <= '0;
              mosi  <= 1'b0;
            end else begin
              sclk   <= 1'b1;
              mosi   <= cmd_sr[CMD_W-1];
              cmd_sr <= cmd_sr << 1;
              bitcnt <= bitcnt - BIT_W'(1);
            end
          end
        end
        ST_GAP: begin
          if (wcnt == gap_last) begin
            state  <= ST_DATA;
            sclk   <= 1'b1;
            bitcnt <= data_top(short_q);
          end else begin
            wcnt <= wcnt + DIV_W'(1);
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (sclk) begin
              sclk  <= 1'b0;
              shreg <= {shreg[RES_W-2:0], miso};
              if (last_bit) state <= ST_DONE;
            end else begin
              sclk   <= 1'b1;
              bitcnt <= bitcnt - BIT_W'(1);
            end
          end
        end
        ST_DONE: begin
          state        <= ST_IDLE;
          sample_valid <= 1'b1;
          sample       <= widen(shreg, short_q);
          cs_n         <= !hold_q;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  cs_before_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);

  // R3
  mosi_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(mosi));

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R11
  overrun_keeps_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && busy && state != ST_DONE) |=> busy);

  // R2
  cs_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && !$past(cs_hold)) |-> $past(fall_evt));

  // R9
  hold_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold_q) |-> !cs_n);

endmodule

// File: rtl/adc_rdy_reader.sv
module adc_rdy_reader #(
  parameter int DIV_W   = 16,
  parameter int RES_W   = 24,
  parameter int SHORT_W = 16,
  parameter int SYNC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drdy_n,
  input  logic             miso,
  input  logic             cs_hold,
  input  logic             bits16,
  input  logic [DIV_W-1:0] half_div,
  input  logic [DIV_W-1:0] cs_setup,
  input  logic [DIV_W-1:0] cmd_gap,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic [RES_W-1:0] sample,
  output logic             sample_valid,
  output logic             overrun
);

  logic fall_evt;
  logic tick;
  logic div_en;

  adc_rd_edge #(.SYNC(SYNC)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .drdy_n   (drdy_n),
    .fall_evt (fall_evt)
  );

  adc_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (div_en),
    .half_div (half_div),
    .tick     (tick)
  );

  adc_rd_fsm #(
    .DIV_W   (DIV_W),
    .RES_W   (RES_W),
    .SHORT_W (SHORT_W),
    .CMD_W   (8),
    .CMD_BYTE(8'h01)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .fall_evt     (fall_evt),
    .tick         (tick),
    .miso         (miso),
    .cs_hold      (cs_hold),
    .bits16       (bits16),
    .cs_setup     (cs_setup),
    .cmd_gap      (cmd_gap),
    .div_en       (div_en),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .mosi         (mosi),
    .sample       (sample),
    .sample_valid (sample_valid),
    .overrun      (overrun)
  );

endmodule

// File: tb/adc_rdy_reader_test.sv
`timescale 1ns/1ps
module adc_rdy_reader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drdy_n = 1'b1;
  logic        miso = 1'b0;
  logic        cs_hold = 1'b0;
  logic        bits16 = 1'b0;
  logic [15:0] half_div = 16'd2;
  logic [15:0] cs_setup = 16'd3;
  logic [15:0] cmd_gap = 16'd4;
  logic        sclk, cs_n, mosi, sample_valid, overrun;
  logic [23:0] sample;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  adc_rdy_reader uut (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .miso(miso),
    .cs_hold(cs_hold), .bits16(bits16), .half_div(half_div),
    .cs_setup(cs_setup), .cmd_gap(cmd_gap), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .sample(sample), .sample_valid(sample_valid),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model: answers on rising SCLK, records command on falling SCLK
  logic [23:0] slave_word = '0;
  logic [7:0]  slave_cmd = '0;
  int          slave_k = 0;
  int          slave_f = 0;

  always @(posedge sclk) begin
    if (slave_k >= 8 && slave_k < 32) miso = slave_word[31 - slave_k];
    else miso = 1'b0;
    slave_k++;
  end

  always @(negedge sclk) begin
    if (slave_f < 8) slave_cmd = {slave_cmd[6:0], mosi};
    slave_f++;
  end

  // reference model: expected pin timeline built per read, one entry per clock
  logic [3:0]  tl[$];
  bit          m1 = 1, m2 = 1, m3 = 1, m_fall;
  logic        e_cs = 1, e_sclk = 0, e_mosi = 0, e_val = 0, e_ov = 0;
  logic [23:0] e_sample = '0, pend_sample = '0;
  logic [3:0]  ent;

  task automatic push_n(input int n, input logic [3:0] v);
    for (int i = 0; i < n; i++) tl.push_back(v);
  endtask

  task automatic build_read();
    int d, setup, gap, nbits;
    logic [7:0] cmd;
    bit hold;
    cmd   = 8'h01;
    hold  = cs_hold;
    d     = (half_div == 0) ? 1 : int'(half_div);
    setup = hold ? 0 : ((cs_setup == 0) ? 1 : int'(cs_setup));
    gap   = (cmd_gap == 0) ? 1 : int'(cmd_gap);
    nbits = (bits16 && !hold) ? 16 : 24;
    pend_sample = (nbits == 16) ? {{8{slave_word[23]}}, slave_word[23:8]} : slave_word;
    // entry layout: {cs_n, sclk, mosi, sample_valid}
    push_n(setup, 4'b0000);
    for (int b = 7; b >= 0; b--) begin
      push_n(d, {2'b01, cmd[b], 1'b0});
      push_n(d, {2'b00, cmd[b], 1'b0});
    end
    push_n(gap, 4'b0000);
    for (int j = 0; j < nbits; j++) begin
      push_n(d, 4'b0100);
      push_n((j == nbits - 1) ? 1 : d, 4'b0000);
    end
    tl.push_back({!hold, 3'b001});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      tl.delete();
      m1 = 1; m2 = 1; m3 = 1;
      e_cs = 1; e_sclk = 0; e_mosi = 0; e_val = 0; e_ov = 0; e_sample = '0;
    end else begin
      m_fall = m3 && !m2;
      m3 = m2; m2 = m1; m1 = drdy_n;
      e_ov = m_fall && (tl.size() > 0);
      if (tl.size() == 0 && m_fall) build_read();
      if (tl.size() > 0) begin
        ent = tl.pop_front();
        e_cs = ent[3]; e_sclk = ent[2]; e_mosi = ent[1]; e_val = ent[0];
        if (ent[0]) e_sample = pend_sample;
      end else begin
        e_cs = !cs_hold; e_sclk = 0; e_mosi = 0; e_val = 0;
      end
    end
  end

  int ov_count = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cs_n == e_cs, "R5 R9 cs_n", cs_n, e_cs);
      chk(sclk == e_sclk, "R4 R6 sclk", sclk, e_sclk);
      chk(mosi == e_mosi, "R3 mosi", mosi, e_mosi);
      chk(sample_valid == e_val, "R10 sample_valid", sample_valid, e_val);
      chk(sample == e_sample, "R7 R8 sample", sample, e_sample);
      chk(overrun == e_ov, "R11 overrun", overrun, e_ov);
      if (overrun) ov_count++;
    end
  end

  task automatic wait_valid();
    while (!sample_valid) @(negedge clk);
  endtask

  task automatic do_read(input logic [23:0] w, input logic [23:0] exp,
                         input int rises, input string tag);
    slave_word = w; slave_k = 0; slave_f = 0; slave_cmd = '0;
    @(negedge clk) drdy_n = 1'b0;
    repeat (4) @(negedge clk);
    drdy_n = 1'b1;
    wait_valid();
    chk(sample == exp, {tag, " result"}, sample, exp);
    chk(slave_cmd == 8'h01, "R3 command byte", slave_cmd, 8'h01);
    chk(slave_k == rises, {tag, " sclk rises"}, slave_k, rises);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(sample_valid == 1'b0, "R1 sample_valid", sample_valid, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(sample == '0, "R1 sample", sample, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (5) @(negedge clk);

    do_read(24'h7A5C31, 24'h7A5C31, 32, "R7 positive");
    do_read(24'h80F00F, 24'h80F00F, 32, "R7 negative");
    bits16 = 1'b1;
    do_read(24'h9ABCDE, 24'hFF9ABC, 24, "R8 short");
    do_read(24'h3456AB, 24'h003456, 24, "R8 short positive");

    cs_hold = 1'b1;
    repeat (3) @(negedge clk);
    do_read(24'h123456, 24'h123456, 32, "R9 hold ignores bits16");
    chk(cs_n == 1'b0, "R9 cs_n stays low", cs_n, 0);
    cs_hold = 1'b0; bits16 = 1'b0;
    repeat (3) @(negedge clk);

    half_div = 16'd0; cs_setup = 16'd0; cmd_gap = 16'd0;
    do_read(24'hC00001, 24'hC00001, 32, "R4 R5 R6 zero settings");

    // R11: second ready edge while the data bits are being clocked
    half_div = 16'd1; cs_setup = 16'd1; cmd_gap = 16'd1;
    ov_count = 0;
    slave_word = 24'h5AA5C3; slave_k = 0; slave_f = 0;
    @(negedge clk) drdy_n = 1'b0;
    repeat (4) @(negedge clk);
    drdy_n = 1'b1;
    repeat (30) @(negedge clk);
    drdy_n = 1'b0;
    repeat (4) @(negedge clk);
    drdy_n = 1'b1;
    wait_valid();
    chk(sample == 24'h5AA5C3, "R11 read completes", sample, 24'h5AA5C3);
    repeat (40) @(negedge clk);
    chk(ov_count == 1, "R11 overrun pulses", ov_count, 1);
    chk(slave_k == 32, "R11 no second read", slave_k, 32);

    // R2: levels without a falling edge start nothing
    slave_k = 0;
    repeat (40) @(negedge clk);
    chk(slave_k == 0, "R2 no start without edge", slave_k, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule